// File: doc/BRIEF.md
# Binary-Curve Point Add/Double Sequencer

This block computes an affine point sum or point double on a curve of the form y² + xy = x³ + ax² + b over GF(2^K). It does not multiply or invert field elements itself. It drives an attached multi-cycle field unit through a start strobe, an operation select and two operand buses. It then takes the result from that unit in fixed cycles set by counters derived from K. The short XOR additions run in the sequencer's own logic, in cycles where a multiplication or an inversion is already in flight. For that reason addition and doubling both take exactly 5K+2 cycles.

A caller presents the coordinates, the curve constant a, a doubling/adding select, a negate-second-operand select and two "operand is the identity" flags, then pulses start. The special cases are resolved in the first cycle without using the field unit: the identity as an operand, vertical chords, and tangents with x = 0. The cycle count stays the same in every case. The result coordinates and an identity flag stay on the outputs until the next accepted start.

Top module: `ec_pt_seq`

## Requirements
- R1: With dbl=0, no identity flag and x1≠x2, the result is x3 = λ² + λ + (x1+x2) + a and y3 = λ·(x1+x3) + x3 + y1, with λ = (y1+y2)/(x1+x2), and inf=0.
- R2: With dbl=1, p1_inf=0 and x1≠0, the result is x3 = λ² + λ + a and y3 = λ·(x1+x3) + x3 + y1, with λ = x1 + y1/x1. The inputs x2, y2, sub and p2_inf are ignored.
- R3: Cycle 1 is the first cycle after the edge that accepts start. On a computed result the field unit is started exactly four times. The start in cycle 2 is an inversion (fu_inv=1). The starts in cycles 2K+1, 3K+1 and 4K+1 are multiplications (fu_inv=0). The unit must present each result with fu_done=1 in cycles 2K+1, 3K+1, 4K+1 and 5K+1.
- R4: busy is high in cycles 1 to 5K+2. done is a single-cycle pulse in cycle 5K+2, for every kind of request.
- R5: For an addition with x1=x2 and y1≠y2 (after the negation of R9), the result is inf=1 with x3=y3=0, and the field unit is never started.
- R6: For an addition with x1=x2 and y1=y2 (after the negation of R9), the result equals the doubling of P1, including the x1=0 case of R8.
- R7: For an addition, p1_inf=1 returns P2 (after the negation of R9) with inf=p2_inf. p2_inf=1 with p1_inf=0 returns P1 with inf=0. Both flags set give inf=1 with x3=y3=0. None of these cases starts the field unit.
- R8: Doubling with p1_inf=1 or x1=0 gives inf=1 with x3=y3=0 and never starts the field unit.
- R9: With dbl=0 and sub=1, P2 is replaced by (x2, x2+y2) before any other step.
- R10: start while busy is ignored. The running request finishes with its own result, and no second request follows.
- R11: After reset, busy, done, fu_start, inf, x3 and y3 are all 0.
- R12: With no start, x3, y3 and inf hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Accept a request when idle |
| dbl | input | 1 | 1 = double P1, 0 = add P1 and P2 |
| sub | input | 1 | Negate P2 before an addition |
| p1_inf | input | 1 | P1 is the identity |
| p2_inf | input | 1 | P2 is the identity |
| x1 | input | K | P1 x coordinate |
| y1 | input | K | P1 y coordinate |
| x2 | input | K | P2 x coordinate |
| y2 | input | K | P2 y coordinate |
| a | input | K | Curve constant a |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse, result valid |
| inf | output | 1 | Result is the identity |
| x3 | output | K | Result x coordinate |
| y3 | output | K | Result y coordinate |
| fu_start | output | 1 | Start a field operation |
| fu_inv | output | 1 | 1 = invert fu_a, 0 = multiply fu_a·fu_b |
| fu_a | output | K | First field operand |
| fu_b | output | K | Second field operand |
| fu_done | input | 1 | Field result valid |
| fu_res | input | K | Field result |

## Verification
The hardest situation to reach is the addition whose two operands turn out equal only after the negation step. In that case the block must switch to the tangent path in cycle 1 and reuse the doubling formulas. The stimulus reaches it with sub=1 and y2 chosen so that x2+y2 equals y1, and a plain equal-point addition is run next to it. Both must match the doubling of the same point. The stimulus also reaches a second start in mid-sequence with different operands. The bench then checks that the original result arrives on schedule and that no second run follows.

// File: rtl/ec_pt_seq.sv
`timescale 1ns/1ps
module ec_pt_seq #(
  parameter int K = 163
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         dbl,
  input  logic         sub,
  input  logic         p1_inf,
  input  logic         p2_inf,
  input  logic [K-1:0] x1,
  input  logic [K-1:0] y1,
  input  logic [K-1:0] x2,
  input  logic [K-1:0] y2,
  input  logic [K-1:0] a,
  output logic         busy,
  output logic         done,
  output logic         inf,
  output logic [K-1:0] x3,
  output logic [K-1:0] y3,
  output logic         fu_start,
  output logic         fu_inv,
  output logic [K-1:0] fu_a,
  output logic [K-1:0] fu_b,
  input  logic         fu_done,
  input  logic [K-1:0] fu_res
);
  localparam int CW = $clog2(5*K+3);
  localparam logic [CW-1:0] T_CHK = CW'(1);
  localparam logic [CW-1:0] T_INV = CW'(2);
  localparam logic [CW-1:0] T_DIV = CW'(2*K+1);
  localparam logic [CW-1:0] T_SQR = CW'(3*K+1);
  localparam logic [CW-1:0] T_PRD = CW'(4*K+1);
  localparam logic [CW-1:0] T_Y3  = CW'(5*K+1);
  localparam logic [CW-1:0] T_END = CW'(5*K+2);

  logic [CW-1:0] cnt;
  logic [K-1:0]  xa, ya, xb, yb, ca, xs, ys, lam;
  logic          md, byp, i1, i2;

  logic          eqx, same;
  logic          sp_byp, sp_md, sp_inf;
  logic [K-1:0]  sp_x, sp_y, lam_n, x3_n;

  assign eqx  = (xa == xb);
  assign same = eqx && (ya == yb);
  assign done = busy && (cnt == T_END);

  assign lam_n = fu_res ^ (md ? xa : '0);
  assign x3_n  = fu_res ^ lam ^ ca ^ (md ? '0 : xs);

  always_comb begin
    sp_byp = 1'b1;
    sp_md  = md;
    sp_inf = 1'b0;
    sp_x   = '0;
    sp_y   = '0;
    if (md) begin
      if (i1 || xa == '0) sp_inf = 1'b1;
      else                sp_byp = 1'b0;
    end else if (i1 && i2) begin
      sp_inf = 1'b1;
    end else if (i1) begin
      sp_x = xb;
      sp_y = yb;
    end else if (i2) begin
      sp_x = xa;
      sp_y = ya;
    end else if (eqx && !same) begin
      sp_inf = 1'b1;
    end else if (same && xa == '0) begin
      sp_inf = 1'b1;
    end else begin
      sp_byp = 1'b0;
      sp_md  = same;
    end
  end

  always_comb begin
    fu_start = 1'b0;
    fu_inv   = 1'b0;
    fu_a     = '0;
    fu_b     = '0;
    if (busy && !byp) begin
      case (cnt)
        T_INV: begin fu_start = 1'b1; fu_inv = 1'b1; fu_a = md ? xa : xs; end
        T_DIV: begin fu_start = 1'b1; fu_a = fu_res; fu_b = md ? ya : ys; end
        T_SQR: begin fu_start = 1'b1; fu_a = lam_n;  fu_b = lam_n; end
        T_PRD: begin fu_start = 1'b1; fu_a = lam;    fu_b = xa ^ x3_n; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; busy <= 1'b0; byp <= 1'b0; md <= 1'b0; i1 <= 1'b0; i2 <= 1'b0;
      xa <= '0; ya <= '0; xb <= '0; yb <= '0; ca <= '0;
      xs <= '0; ys <= '0; lam <= '0;
      x3 <= '0; y3 <= '0; inf <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= T_CHK;
        byp  <= 1'b0;
        md   <= dbl;
        i1   <= p1_inf;
        i2   <= p2_inf & ~dbl;
        xa   <= x1;
        ya   <= y1;
        xb   <= x2;
        yb   <= (sub && !dbl) ? (x2 ^ y2) : y2;
        ca   <= a;
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == T_CHK) begin
        xs  <= xa ^ xb;
        byp <= sp_byp;
        md  <= sp_md;
        inf <= sp_inf;
        if (sp_byp) begin
          x3 <= sp_x;
          y3 <= sp_y;
        end
      end
      if (cnt == T_INV) ys <= ya ^ yb;
      if (!byp && cnt == T_SQR) lam <= lam_n;
      if (!byp && cnt == T_PRD) x3 <= x3_n;
      if (!byp && cnt == T_Y3)  y3 <= fu_res ^ x3 ^ ya;
      if (cnt == T_END) busy <= 1'b0;
    end
  end

  // R3: the field unit must hand back a result in every capture cycle
  assert_result_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !byp && (cnt == T_DIV || cnt == T_SQR || cnt == T_PRD || cnt == T_Y3)) |-> fu_done);

  // R3: issues are isolated single-cycle strobes
  assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fu_start |=> !fu_start);

  // R4: done ends the request
  assert_done_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  // R10: operands stay latched while a request runs
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(xa) && $stable(ya) && $stable(xb) && $stable(yb) && $stable(ca)));

  // R12: results hold while idle without a start
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x3) && $stable(y3) && $stable(inf)));
endmodule

// File: tb/ec_pt_seq_tb_top.sv
`timescale 1ns/1ps
module ec_pt_seq_tb_top;
  localparam int K    = 8;
  localparam int LAST = 5*K+2;
  localparam int NV   = 13;

  logic clk = 1'b0;
  logic rst_n, start, dbl, sub, p1_inf, p2_inf;
  logic [K-1:0] x1, y1, x2, y2, a;
  logic busy, done, inf, fu_start, fu_inv, fu_done;
  logic [K-1:0] x3, y3, fu_a, fu_b, fu_res;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ec_pt_seq #(.K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl), .sub(sub),
    .p1_inf(p1_inf), .p2_inf(p2_inf), .x1(x1), .y1(y1), .x2(x2), .y2(y2), .a(a),
    .busy(busy), .done(done), .inf(inf), .x3(x3), .y3(y3),
    .fu_start(fu_start), .fu_inv(fu_inv), .fu_a(fu_a), .fu_b(fu_b),
    .fu_done(fu_done), .fu_res(fu_res)
  );

  function automatic logic [7:0] gmul(input logic [7:0] p, input logic [7:0] q);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      if (q[i]) r ^= p;
      p = p[7] ? ((p << 1) ^ 8'h1B) : (p << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] p);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < 254; i++) r = gmul(r, p);
    return r;
  endfunction

  // behavioural field unit: inversion 2K-1 cycles, multiplication K cycles
  logic [7:0] rsp_val;
  int rsp_t;
  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_t   <= 0;
      rsp_val <= '0;
    end else if (fu_start) begin
      rsp_val <= fu_inv ? ginv(fu_a) : gmul(fu_a, fu_b);
      rsp_t   <= fu_inv ? 2*K-1 : K;
    end else if (rsp_t > 0) begin
      rsp_t <= rsp_t - 1;
    end
  end
  assign fu_done = (rsp_t == 1);
  assign fu_res  = fu_done ? rsp_val : '0;

  // reference: {uses field unit, inf, x3, y3}
  function automatic logic [17:0] ref_pt(input logic [43:0] v);
    logic d, s, j1, j2;
    logic [7:0] vx1, vy1, vx2, vy2, va, l, rx, ry;
    {d, s, j1, j2, vx1, vy1, vx2, vy2, va} = v;
    if (d) begin
      j2 = 1'b0;
    end else if (s) begin
      vy2 = vx2 ^ vy2;                       // R9
    end
    if (!d) begin
      if (j1 && j2) return {2'b01, 16'h0};   // R7
      if (j1) return {2'b00, vx2, vy2};
      if (j2) return {2'b00, vx1, vy1};
      if (vx1 == vx2 && vy1 != vy2) return {2'b01, 16'h0};  // R5
      if (vx1 == vx2) d = 1'b1;              // R6
    end
    if (d) begin
      if (j1 || vx1 == 8'h00) return {2'b01, 16'h0};        // R8
      l  = vx1 ^ gmul(vy1, ginv(vx1));
      rx = gmul(l, l) ^ l ^ va;
    end else begin
      l  = gmul(vy1 ^ vy2, ginv(vx1 ^ vx2));
      rx = gmul(l, l) ^ l ^ vx1 ^ vx2 ^ va;
    end
    ry = gmul(l, vx1 ^ rx) ^ rx ^ vy1;
    return {2'b10, rx, ry};
  endfunction

  // {req, dbl sub p1_inf p2_inf, x1, y1, x2, y2, a}
  localparam logic [47:0] VEC [NV] = '{
    48'h10_12_34_56_78_01,   // R1
    48'h10_A5_3C_0F_E1_00,   // R1
    48'h28_57_83_00_00_01,   // R2
    48'h28_C3_11_FF_FF_2A,   // R2 with ignored P2
    48'h94_12_34_56_78_01,   // R9
    48'h50_40_11_40_22_01,   // R5
    48'h60_57_83_57_83_01,   // R6
    48'h88_00_9A_00_00_01,   // R8
    48'h72_11_22_33_44_01,   // R7
    48'h71_11_22_33_44_01,   // R7
    48'h73_11_22_33_44_01,   // R7
    48'h96_11_22_33_44_01,   // R9 with R7
    48'h64_40_51_40_11_01    // R6 reached through R9
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [43:0] v, input bit poke,
                       output int got, output int nst, output bit bad);
    @(negedge clk);
    {dbl, sub, p1_inf, p2_inf, x1, y1, x2, y2, a} = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; nst = 0; bad = 1'b0;
    for (int idx = 1; idx <= LAST + 4; idx++) begin
      if (poke && idx == 5) begin x1 = ~x1; dbl = ~dbl; start = 1'b1; end
      if (poke && idx == 6) start = 1'b0;
      if (fu_start) begin
        nst++;
        if (!((idx == 2 && fu_inv) || (!fu_inv && (idx == 2*K+1 || idx == 3*K+1 || idx == 4*K+1))))
          bad = 1'b1;
      end
      if (done) begin got = idx; break; end
      @(negedge clk);
    end
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [17:0] e;
    logic [15:0] held;
    int got, nst;
    bit bad;
    string tag;
    rst_n = 1'b0; start = 1'b0; dbl = 1'b0; sub = 1'b0; p1_inf = 1'b0; p2_inf = 1'b0;
    x1 = '0; y1 = '0; x2 = '0; y2 = '0; a = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, fu_start, inf, x3, y3} == '0, "R11", {busy, done, fu_start, inf, x3, y3}, 0);

    for (int n = 0; n < NV; n++) begin
      tag = $sformatf("R%0d", VEC[n][47:44]);
      e = ref_pt(VEC[n][43:0]);
      do_op(VEC[n][43:0], 1'b0, got, nst, bad);
      chk(got == LAST, "R4 done cycle", got, LAST);
      chk(nst == (e[17] ? 4 : 0), {tag, " R3 issue count"}, nst, e[17] ? 4 : 0);
      chk(!bad, "R3 issue cycle", bad, 0);
      chk({inf, x3, y3} == e[16:0], tag, {inf, x3, y3}, e[16:0]);
      @(negedge clk);
      chk(!busy && !done, "R4 single pulse", {busy, done}, 0);
    end

    // R6: equal-point addition matches the doubling result
    chk(ref_pt(VEC[6][43:0]) == ref_pt(VEC[2][43:0]), "R6 vs R2",
        ref_pt(VEC[6][43:0]), ref_pt(VEC[2][43:0]));

    // R10: a second start mid-run is ignored
    e = ref_pt(VEC[0][43:0]);
    do_op(VEC[0][43:0], 1'b1, got, nst, bad);
    chk(got == LAST, "R10 done cycle", got, LAST);
    chk({inf, x3, y3} == e[16:0], "R10 result", {inf, x3, y3}, e[16:0]);
    @(negedge clk);
    chk(!busy, "R10 no second run", busy, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !fu_start, "R10 idle", {busy, fu_start}, 0);

    // R12: outputs hold while inputs wander without a start
    held = {x3, y3};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      x1 = x1 + 8'h13; y2 = y2 ^ 8'h5A; dbl = ~dbl; p1_inf = ~p1_inf;
    end
    chk({x3, y3} == held && !inf, "R12 hold", {inf, x3, y3}, {1'b0, held});

    finish_up();
  end
endmodule